// File: doc/BRIEF.md
# Serial-Load Converter Code Register

This block is the digital front end of a 12-bit voltage-output converter. It takes a three-wire serial stream: a serial clock, a data line, and an active-low select line. That select line also acts as the load strobe. While select is low, each rising serial clock edge shifts one data bit into a shift register, most significant bit first. When select returns high, the whole shift register is copied into the code register that drives the converter. At the same moment a single-cycle update pulse is raised.

The last stage of the shift register drives a serial data output. Words shifted into one device therefore push its previous word out, MSB first, to the next device in a chain. All three pins are asynchronous to the block. They are sampled by a fast system clock through two-flop synchronisers, and every edge is detected from those samples. The system clock must run at least four times faster than the serial clock. A synchronous active-low reset clears the registers before the first transfer.

Top module: `sdac_serial_front`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `dac_code` is 0, `dac_upd` is 0 and `sdo_pin` is 0. The shift register also holds 0.
- R2: A 12-clock frame sent MSB first (bit 11 first, bit 0 last) while `sel_n_pin` is low, followed by a rising edge of `sel_n_pin`, makes `dac_code` equal to the word sent.
- R3: While `sel_n_pin` is high, activity on `sck_pin` and `sdi_pin` leaves the shift register unchanged. This is seen as a constant `sdo_pin` and, after a later zero-clock load, as an unchanged code.
- R4: `sdo_pin` equals the shift register's bit 11. It changes only on an accepted rising serial clock edge, so a new frame pushes out the previous contents MSB first.
- R5: If more than 12 clocks arrive in one select-low window, only the last 12 bits shifted in are loaded.
- R6: If n < 12 clocks arrive in a window, the loaded code is ((previous shift contents << n) | new bits) modulo 4096.
- R7: A select-low window with no serial clock edges, followed by a rising select edge, reloads the current shift register contents into `dac_code`.
- R8: Each rising edge of `sel_n_pin` produces exactly one `dac_upd` pulse, one system clock cycle wide, in the same cycle that `dac_code` takes its new value.
- R9: `dac_code` does not change in any cycle in which `dac_upd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| sdi_pin | input | 1 | Serial data pin, captured on rising serial clock |
| sel_n_pin | input | 1 | Active-low select; its rising edge loads the code |
| sdo_pin | output | 1 | Last shift register stage, for daisy-chaining |
| dac_code | output | CODE_W | Parallel converter code |
| dac_upd | output | 1 | One-cycle pulse on each code register update |

## Verification
The main load path is driven with every one-hot word, and with a set of arithmetically generated mixed words. The one-hot words expose any bit-order reversal or stuck bit. The mixed words expose dropped or doubled shifts. Each frame's `sdo_pin` is compared bit by bit against the previous frame's contents, which separates a correct chain output from one that taps the wrong stage or updates at the wrong time.

Further patterns cover the remaining boundaries:
- Over-length (15-bit) and short (5-bit) frames show whether the register keeps exactly the last 12 bits.
- Serial clock bursts with select high show whether the clock is gated correctly.
- A zero-clock load that follows them shows whether the contents survived.

// File: rtl/sdac_pkg.sv
// Package: shared widths and the bundle type for synchronised serial pins.
package sdac_pkg;

    // Bundle of the three serial pins after synchronisation.
    typedef struct packed {
        logic sck;
        logic sdi;
        logic sel_n;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    // Idle pin levels: clock low, data low, select high (deselected).
    localparam pins_t PINS_IDLE = '{sck: 1'b0, sdi: 1'b0, sel_n: 1'b1};

endpackage

// File: rtl/sdac_sync.sv
// Module: sdac_sync
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes: each pin is stable for more than one clk period between changes.
// Reset loads RST_VAL into every stage, so idle levels produce no false edge.
module sdac_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the pin samples through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
// Module: sdac_edge
// Finds rising edges of the synchronised serial clock and select lines.
// Serial clock edges are passed on only while select is low.
// Assumes: the inputs come from sdac_sync and are already clk-synchronous.
module sdac_edge
    import sdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_s,
    output logic  sck_rise,
    output logic  sel_rise,
    output logic  sel_prev
);

    logic sck_q;
    logic sel_q;

    // Keep the previous synchronised level of the clock and select lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= PINS_IDLE.sck;
            sel_q <= PINS_IDLE.sel_n;
        end else begin
            sck_q <= pins_s.sck;
            sel_q <= pins_s.sel_n;
        end
    end

    // Decode the edges; the clock edge is gated by an active select.
    always_comb begin
        sck_rise = pins_s.sck & ~sck_q & ~pins_s.sel_n;
        sel_rise = pins_s.sel_n & ~sel_q;
    end

    assign sel_prev = sel_q;

endmodule

// File: rtl/sdac_shift.sv
// Module: sdac_shift
// MSB-first serial-in shift register. Its top stage is the chain output.
// Assumes: shift_en is a single-cycle strobe, one per serial clock edge.
module sdac_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic         sdo
);

    // Shift one bit in at the bottom on each accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[W-2:0], din};
        end
    end

    assign sdo = q[W-1];

endmodule

// File: rtl/sdac_hold.sv
// Module: sdac_hold
// Parallel code register with an update pulse.
// Assumes: load is a single-cycle strobe; the pulse is raised in the same
// cycle that the new code appears.
module sdac_hold #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] code,
    output logic         upd
);

    // Capture the shift contents on load, and mark the update for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            upd  <= 1'b0;
        end else begin
            upd <= load;
            if (load) begin
                code <= d;
            end
        end
    end

endmodule

// File: rtl/sdac_serial_front.sv
// Module: sdac_serial_front
// Top of the serial-load converter code register. The pins are synchronised,
// the clock and select edges are detected, the bits are shifted MSB first
// while select is low, and the word is loaded when select rises.
// Assumes: clk runs at least 4x the serial clock; synchronous active-low reset.
module sdac_serial_front #(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_pin,
    input  logic              sdi_pin,
    input  logic              sel_n_pin,
    output logic              sdo_pin,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_upd
);
    import sdac_pkg::*;

    pins_t             pins_raw;
    pins_t             pins_s;
    logic              sck_rise;
    logic              sel_rise;
    logic              sel_prev;
    logic              sel_sync;
    logic [CODE_W-1:0] shift_q;

    // Gather the pins into one bundle for the synchroniser.
    always_comb begin
        pins_raw.sck   = sck_pin;
        pins_raw.sdi   = sdi_pin;
        pins_raw.sel_n = sel_n_pin;
    end

    sdac_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (PINS_W),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s)
    );

    sdac_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_s  (pins_s),
        .sck_rise(sck_rise),
        .sel_rise(sel_rise),
        .sel_prev(sel_prev)
    );

    sdac_shift #(.W(CODE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(sck_rise),
        .din     (pins_s.sdi),
        .q       (shift_q),
        .sdo     (sdo_pin)
    );

    sdac_hold #(.W(CODE_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (sel_rise),
        .d    (shift_q),
        .code (dac_code),
        .upd  (dac_upd)
    );

    assign sel_sync = pins_s.sel_n;

endmodule

// File: rtl/sdac_serial_front_chk.sv
// Module: sdac_serial_front_chk
// Property checker for sdac_serial_front, attached to it by bind.
module sdac_serial_front_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_sync,
    input logic              sel_prev,
    input logic [CODE_W-1:0] shift_q,
    input logic              sdo,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_upd
);

    // R1: a reset cycle leaves every output and the shift contents at zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0 && !dac_upd && !sdo && shift_q == '0));

    // R2: a rising select loads the shift contents and raises the pulse.
    assert_load_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_sync && !sel_prev) |=> (dac_upd && dac_code == $past(shift_q)));

    // R3: with select high, the shift contents and chain output hold.
    assert_gated_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_sync |=> ($stable(shift_q) && $stable(sdo)));

    // R8: the update pulse is exactly one cycle wide.
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd |=> !dac_upd);

    // R9: the code changes only together with the pulse.
    assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_upd |-> $stable(dac_code));

endmodule

bind sdac_serial_front sdac_serial_front_chk #(.CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_sync(sel_sync),
    .sel_prev(sel_prev),
    .shift_q (shift_q),
    .sdo     (sdo_pin),
    .dac_code(dac_code),
    .dac_upd (dac_upd)
);

// File: tb/sdac_serial_front_bench.sv
// Bench for sdac_serial_front: frames of several lengths, sweeps over
// one-hot and generated words, and clock activity while deselected.
module sdac_serial_front_bench;

    localparam int W    = 12;
    localparam int HOLD = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck_pin = 1'b0;
    logic         sdi_pin = 1'b0;
    logic         sel_n_pin = 1'b1;
    logic         sdo_pin;
    logic [W-1:0] dac_code;
    logic         dac_upd;

    int checks = 0;
    int failures = 0;
    int upd_cnt = 0;
    logic [W-1:0] model_sh = '0;
    logic [W-1:0] model_dac = '0;

    always #10 clk = ~clk;

    sdac_serial_front #(.CODE_W(W), .SYNC_STAGES(2)) u_sdac_serial_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_pin  (sck_pin),
        .sdi_pin  (sdi_pin),
        .sel_n_pin(sel_n_pin),
        .sdo_pin  (sdo_pin),
        .dac_code (dac_code),
        .dac_upd  (dac_upd)
    );

    // Count update pulses, sampled away from the active edge.
    always @(negedge clk) if (dac_upd) upd_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send n bits of val MSB first, checking the chain output after each bit.
    task automatic send_bits(input logic [31:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi_pin = val[i];
            idle(HOLD);
            sck_pin = 1'b1;
            idle(HOLD);
            model_sh = {model_sh[W-2:0], val[i]};
            chk("R4 sdo after shift", {31'd0, sdo_pin}, {31'd0, model_sh[W-1]});
            sck_pin = 1'b0;
            idle(HOLD);
        end
    endtask

    // Select low, n bits, select high; check the loaded code and the pulse.
    task automatic frame(input logic [31:0] val, input int n, input string tag);
        sel_n_pin = 1'b0;
        idle(HOLD);
        send_bits(val, n);
        upd_cnt = 0;
        sel_n_pin = 1'b1;
        idle(2 * HOLD);
        model_dac = model_sh;
        chk(tag, {20'd0, dac_code}, {20'd0, model_dac});
        chk("R8 one pulse per load", upd_cnt, 1);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(5);
        chk("R1 code in reset", {20'd0, dac_code}, 0);
        chk("R1 pulse in reset", {31'd0, dac_upd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code after reset", {20'd0, dac_code}, 0);
        chk("R1 sdo after reset", {31'd0, sdo_pin}, 0);
        chk("R1 pulse after reset", {31'd0, dac_upd}, 0);
        upd_cnt = 0;
        idle(10);
        chk("R8 no pulse while idle", upd_cnt, 0);

        // R2 / R4: two full words; the second pushes the first out of sdo.
        frame(32'hA5C, W, "R2 word A");
        frame(32'h3F1, W, "R2 word B");

        // R3 / R9: clock bursts while deselected change nothing.
        upd_cnt = 0;
        sdi_pin = 1'b1;
        for (int k = 0; k < 10; k++) begin
            sck_pin = 1'b1;
            idle(HOLD);
            sck_pin = 1'b0;
            idle(HOLD);
            chk("R3 sdo held while deselected", {31'd0, sdo_pin}, {31'd0, model_sh[W-1]});
        end
        chk("R9 code held while deselected", {20'd0, dac_code}, {20'd0, model_dac});
        chk("R8 no pulse without select edge", upd_cnt, 0);

        // R7 (and R3): a zero-clock load reloads unchanged contents.
        frame(32'h0, 0, "R7 zero-clock reload");
        chk("R3 contents survived clock bursts", {20'd0, dac_code}, 32'h3F1);

        // R5: an over-length frame keeps the last 12 bits.
        frame(32'h5A3B, 15, "R5 long frame");
        chk("R5 last twelve bits", {20'd0, dac_code}, 32'h5A3B & 32'hFFF);

        // R6: a short frame merges with the old contents.
        frame(32'h13, 5, "R6 short frame");
        chk("R6 merged code", {20'd0, dac_code}, ((32'h23B << 5) | 32'h13) & 32'hFFF);

        // R2 sweep: every one-hot word, then generated mixed words.
        for (int b = 0; b < W; b++) begin
            frame(32'd1 << b, W, "R2 one-hot sweep");
        end
        for (int k = 0; k < 24; k++) begin
            frame((k * 32'h1F3 + 32'h7) & 32'hFFF, W, "R2 mixed sweep");
        end
        frame(32'hFFF, W, "R2 all ones");
        frame(32'h000, W, "R2 all zeros");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule